// File: doc/BRIEF.md
# Handshaked Synchronous Serial Port

This block is a clocked serial shift port that moves one word at a time to or from a remote partner, with both sides pacing each other through a ready handshake. Software loads a word through a small register port. That load raises the ready output, which tells the partner this side has data waiting. The port then waits for the partner's ready input. With the internal clock selected, the port produces its own transfer clock from the system clock through a programmable divider. The clock only starts once the partner's ready has been steady for one and a half transfer-clock periods. With the external clock selected, the partner supplies the clock, and the ready input together with the data load arms the busy output.

A transfer is either a full byte or a programmable bit count. Bits leave least-significant first on the falling clock edge, and incoming bits are captured on the rising edge. Received bits enter the data register from the top as it shifts right. A sticky completion flag marks the end of each transfer and clears when software reads the data register.

The register port has four addresses. Address 0 holds data. Address 1 is control: bit 0 enable, bit 1 external-clock select, bit 2 programmable-length select, bit 3 ready-input active-low, and bits 6:4 the length setting. Address 2 holds the divider value. Address 3 is a read-only status: bit 0 done, bit 1 busy.

Top module: `hsk_serial_port`

## Requirements
- R1: While the enable bit (control bit 0) is 0, `rdy_o` stays 0 and writes to the data register leave its contents unchanged; clearing enable drops `rdy_o` one cycle later.
- R2: With enable set and no transfer running, a write to the data register raises `rdy_o` at the clock edge that takes the write.
- R3: `rdy_o` returns to 0 at the first falling edge of the transfer clock (generated or external).
- R4: `rdy_o_n` is always the complement of `rdy_o`.
- R5: With the internal clock, one half-period is (divider+1) system cycles, and the first falling edge of `sclk_o` comes no sooner than three half-periods of continuously active ready input. A shorter active pulse produces no clock.
- R6: Once the first falling edge has occurred, making the ready input inactive does not stop the transfer.
- R7: A transfer is 8 bits when control bit 2 is 0, and (length setting + 1) bits when it is 1; both are captured when the data word is written.
- R8: `sclk_o` idles high, gives exactly as many falling and rising edges as the transfer length, and then stays high. `busy_o` is 1 from the start of the transfer until its last rising edge.
- R9: With the external clock (control bit 1 = 1), `busy_o` rises only after a data write followed by an active ready input. No qualification delay applies.
- R10: `sdata_o` presents bits LSB first, changing on falling edges. `sdata_i` is captured on rising edges into the MSB as the register shifts right, so a looped-back N-bit transfer leaves the data word rotated right by N.
- R11: Status bit 0 (done) is set at the end of a transfer and cleared by a read of the data register.
- R12: Control bit 3 selects the ready-input polarity: 0 means high is active, 1 means low is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read of address 0 clears done) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| sclk_i | input | 1 | Transfer clock from partner (external mode) |
| sclk_o | output | 1 | Generated transfer clock, idles high |
| sdata_i | input | 1 | Serial data in |
| sdata_o | output | 1 | Serial data out |
| rdy_i | input | 1 | Partner ready, polarity set by control bit 3 |
| rdy_o | output | 1 | Ready to partner, active high |
| rdy_o_n | output | 1 | Ready to partner, active low |
| busy_o | output | 1 | Transfer in progress |

## Verification
Register writes act at the next clock edge, so the bench samples `rdy_o` at the falling edge that follows the write. The ready input passes through a two-stage synchronizer before the qualification counter sees it. For that reason the clock start is measured in system cycles from the pin change and must fall in a window of three half-periods plus up to four cycles of synchronizer and register delay. Edge counts, the idle level, busy, done and the rotated data word are all checked only after `busy_o` has dropped and a further margin has passed. The external-clock case spaces its clock edges six cycles apart, which is well past the synchronizer latency.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  typedef enum logic [1:0] {
    HSP_IDLE  = 2'd0,
    HSP_ARMED = 2'd1,
    HSP_XFER  = 2'd2
  } hsp_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int CTL_EN   = 0;
  localparam int CTL_EXT  = 1;
  localparam int CTL_ARB  = 2;
  localparam int CTL_RLOW = 3;
  localparam int CTL_LEN  = 4;

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      assign pipe_d = d_i;
    end else begin : g_chain
      assign pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/hsp_divider.sv
module hsp_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             tick;

  always_comb begin
    tick  = run_i && (cnt_q == div_i);
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = tick;

  AST_DIV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0)) else $error("divider not cleared"); // R5

endmodule

// File: rtl/hsp_qualify.sv
module hsp_qualify #(
  parameter int QUAL_HALVES = 3,
  localparam int QW = $clog2(QUAL_HALVES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic start_o
);

  logic [QW-1:0] cnt_q;
  logic [QW-1:0] cnt_d;
  logic          hit;

  always_comb begin
    hit   = tick_i && (cnt_q == QW'(QUAL_HALVES - 1));
    cnt_d = cnt_q;
    if (clr_i)                cnt_d = '0;
    else if (tick_i && !hit)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign start_o = !clr_i && hit;

  AST_QUAL_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> tick_i) else $error("start without half-period tick"); // R5

endmodule

// File: rtl/hsp_shifter.sv
module hsp_shifter #(
  parameter int  DATA_W = 8,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic              sin_i,
  input  logic [CNT_W-1:0]  last_idx_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sout_o,
  output logic              last_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic              sout_q, sout_d;
  logic              last;

  always_comb begin
    last   = rise_i && (bit_q == last_idx_i);
    sh_d   = sh_q;
    bit_d  = bit_q;
    sout_d = sout_q;
    if (load_i) begin
      sh_d  = load_data_i;
      bit_d = '0;
    end else begin
      if (fall_i) sout_d = sh_q[0];
      if (rise_i) begin
        sh_d  = {sin_i, sh_q[DATA_W-1:1]};
        bit_d = last ? '0 : bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      sout_q <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      sout_q <= sout_d;
    end
  end

  assign data_o = sh_q;
  assign sout_o = sout_q;
  assign last_o = last;

  AST_BIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rise_i |-> (bit_q <= last_idx_i)) else $error("bit index past length"); // R7

  AST_SOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && !load_i) |=> $stable(sout_o)) else $error("sout moved off a falling edge"); // R10

endmodule

// File: rtl/hsk_serial_port.sv
module hsk_serial_port
  import hsp_pkg::*;
#(
  parameter int  DATA_W      = 8,
  parameter int  DIV_W       = 8,
  parameter int  QUAL_HALVES = 3,
  parameter int  SYNC_STAGES = 2,
  localparam int CNT_W       = $clog2(DATA_W),
  localparam int SPAN_W      = DIV_W + $clog2(QUAL_HALVES + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sclk_i,
  output logic              sclk_o,
  input  logic              sdata_i,
  output logic              sdata_o,
  input  logic              rdy_i,
  output logic              rdy_o,
  output logic              rdy_o_n,
  output logic              busy_o
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // configuration registers
  logic [DATA_W-1:0] ctl_q, ctl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              ctl_en, ctl_ext, ctl_arb, ctl_rlow;
  logic [CNT_W-1:0]  ctl_len;
  logic              wr_ctl, wr_div, wr_data, rd_data;

  assign wr_ctl  = reg_wr && (reg_addr == ADDR_CTL);
  assign wr_div  = reg_wr && (reg_addr == ADDR_DIV);
  assign wr_data = reg_wr && (reg_addr == ADDR_DATA);
  assign rd_data = reg_rd && (reg_addr == ADDR_DATA);

  assign ctl_en   = ctl_q[CTL_EN];
  assign ctl_ext  = ctl_q[CTL_EXT];
  assign ctl_arb  = ctl_q[CTL_ARB];
  assign ctl_rlow = ctl_q[CTL_RLOW];
  assign ctl_len  = ctl_q[CTL_LEN +: CNT_W];

  always_comb begin
    ctl_d = wr_ctl ? reg_wdata : ctl_q;
    div_d = wr_div ? reg_wdata[DIV_W-1:0] : div_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q <= '0;
      div_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      div_q <= div_d;
    end
  end

  // pin synchronizers
  logic rdy_sync, sclk_sync, sclk_prev_q;
  logic rdy_act, ext_fall, ext_rise;

  hsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_rdy_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(rdy_i), .q_o(rdy_sync));

  hsp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sclk_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(sclk_i), .q_o(sclk_sync));

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sclk_prev_q <= 1'b1;
    else            sclk_prev_q <= sclk_sync;
  end

  assign rdy_act  = ctl_rlow ? !rdy_sync : rdy_sync;
  assign ext_fall = sclk_prev_q && !sclk_sync;
  assign ext_rise = !sclk_prev_q && sclk_sync;

  // transfer state
  hsp_state_e        st_q, st_d;
  logic              rdy_q, rdy_d;
  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  last_idx_q, last_idx_d;

  logic qual_cond, div_run, half_tick, qual_start;
  logic start_int, start_ext, fall_ev, rise_ev, last_bit, load;
  logic [DATA_W-1:0] sh_data;
  logic              sh_out;

  assign qual_cond = (st_q == HSP_ARMED) && rdy_act && ctl_en && !ctl_ext;
  assign div_run   = ctl_en && !ctl_ext && (qual_cond || (st_q == HSP_XFER));

  hsp_divider #(.DIV_W(DIV_W)) i_divider (
    .clk(clk), .rst_n(rst_int_n), .run_i(div_run), .div_i(div_q), .tick_o(half_tick));

  hsp_qualify #(.QUAL_HALVES(QUAL_HALVES)) i_qualify (
    .clk(clk), .rst_n(rst_int_n), .clr_i(!qual_cond), .tick_i(half_tick),
    .start_o(qual_start));

  always_comb begin
    start_int = qual_start && (st_q == HSP_ARMED);
    start_ext = ctl_en && ctl_ext && (st_q == HSP_ARMED) && rdy_act;
    if (ctl_ext) begin
      fall_ev = (st_q == HSP_XFER) && ext_fall;
      rise_ev = (st_q == HSP_XFER) && ext_rise;
    end else begin
      fall_ev = start_int || ((st_q == HSP_XFER) && half_tick && sclk_q);
      rise_ev = (st_q == HSP_XFER) && half_tick && !sclk_q;
    end
    load       = wr_data && ctl_en && (st_q != HSP_XFER);
    last_idx_d = last_idx_q;
    if (load) last_idx_d = ctl_arb ? ctl_len : CNT_W'(DATA_W - 1);
  end

  hsp_shifter #(.DATA_W(DATA_W)) i_shifter (
    .clk(clk), .rst_n(rst_int_n), .load_i(load), .load_data_i(reg_wdata),
    .fall_i(fall_ev), .rise_i(rise_ev), .sin_i(sdata_i), .last_idx_i(last_idx_q),
    .data_o(sh_data), .sout_o(sh_out), .last_o(last_bit));

  always_comb begin
    st_d   = st_q;
    rdy_d  = rdy_q;
    busy_d = busy_q;
    sclk_d = sclk_q;
    done_d = done_q;
    if (rd_data) done_d = 1'b0;
    if (!ctl_en) begin
      st_d   = HSP_IDLE;
      rdy_d  = 1'b0;
      busy_d = 1'b0;
      sclk_d = 1'b1;
    end else begin
      case (st_q)
        HSP_IDLE: begin
          if (wr_data) begin
            st_d  = HSP_ARMED;
            rdy_d = 1'b1;
          end
        end
        HSP_ARMED: begin
          if (start_int) begin
            st_d   = HSP_XFER;
            rdy_d  = 1'b0;
            busy_d = 1'b1;
            sclk_d = 1'b0;
          end else if (start_ext) begin
            st_d   = HSP_XFER;
            busy_d = 1'b1;
          end
        end
        HSP_XFER: begin
          if (fall_ev) begin
            rdy_d = 1'b0;
            if (!ctl_ext) sclk_d = 1'b0;
          end
          if (rise_ev) begin
            sclk_d = 1'b1;
            if (last_bit) begin
              st_d   = HSP_IDLE;
              busy_d = 1'b0;
              done_d = 1'b1;
            end
          end
        end
        default: st_d = HSP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= HSP_IDLE;
      rdy_q      <= 1'b0;
      busy_q     <= 1'b0;
      sclk_q     <= 1'b1;
      done_q     <= 1'b0;
      last_idx_q <= CNT_W'(DATA_W - 1);
    end else begin
      st_q       <= st_d;
      rdy_q      <= rdy_d;
      busy_q     <= busy_d;
      sclk_q     <= sclk_d;
      done_q     <= done_d;
      last_idx_q <= last_idx_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_DATA: reg_rdata = sh_data;
      ADDR_CTL:  reg_rdata = ctl_q;
      ADDR_DIV:  reg_rdata = DATA_W'(div_q);
      default:   reg_rdata = DATA_W'({busy_q, done_q});
    endcase
  end

  assign sclk_o  = sclk_q;
  assign sdata_o = sh_out;
  assign rdy_o   = rdy_q;
  assign rdy_o_n = !rdy_q;
  assign busy_o  = busy_q;

  // qualification span observer (used only by the check below)
  logic [SPAN_W-1:0] span_q, span_d;
  logic [SPAN_W-1:0] span_need;

  always_comb begin
    span_d    = qual_cond ? ((span_q == '1) ? span_q : span_q + 1'b1) : '0;
    span_need = SPAN_W'(QUAL_HALVES) * (SPAN_W'(div_q) + 1'b1) - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) span_q <= '0;
    else            span_q <= span_d;
  end

  AST_RDY_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctl_en |=> !rdy_o) else $error("ready while disabled"); // R1

  AST_RDY_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sclk_o |-> !rdy_o) else $error("ready held into a transfer"); // R3

  AST_QUAL_SPAN: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_int |-> (span_q >= span_need)) else $error("clock before qualification"); // R5

  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((st_q == HSP_XFER) && ctl_en && !last_bit) |=> (st_q == HSP_XFER))
    else $error("transfer aborted"); // R6

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (st_q != HSP_XFER) |-> sclk_o) else $error("clock low outside a transfer"); // R8

  AST_EXT_TRIGGER: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_ext && $rose(busy_o)) |-> $past(rdy_act)) else $error("busy without ready"); // R9

endmodule

// File: tb/test_hsk_serial_port.sv
module test_hsk_serial_port;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr, reg_rd;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sclk_i, sclk_o, sdata_i, sdata_o;
  logic       rdy_i, rdy_o, rdy_o_n, busy_o;

  always #5 clk = ~clk;

  assign sdata_i = sdata_o;

  hsk_serial_port i_hsk_serial_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk_i(sclk_i), .sclk_o(sclk_o),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .rdy_i(rdy_i), .rdy_o(rdy_o),
    .rdy_o_n(rdy_o_n), .busy_o(busy_o));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int falls = 0;
  int rises = 0;
  int first_fall = 0;

  always @(posedge clk) cyc++;
  always @(negedge sclk_o) begin
    if (falls == 0) first_fall = cyc;
    falls++;
  end
  always @(posedge sclk_o) rises++;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input string what, input int act,
                         input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic int rotr(input int d, input int n);
    return ((d >> n) | (d << (8 - n))) & 255;
  endfunction

  function automatic logic [7:0] ctl(input int en, input int ext, input int arb,
                                     input int rlow, input int len);
    return 8'((en & 1) | ((ext & 1) << 1) | ((arb & 1) << 2) | ((rlow & 1) << 3)
              | ((len & 7) << 4));
  endfunction

  task automatic wait_busy_low();
    for (int k = 0; k < 4000 && busy_o; k++) @(negedge clk);
  endtask

  task automatic run_int(input int d, input int arb, input int len, input int data,
                         input int rlow);
    logic [7:0] v;
    int n, lo;
    n  = arb ? len + 1 : 8;
    lo = 3 * (d + 1);
    wr(2'd2, 8'(d));
    wr(2'd1, ctl(1, 0, arb, rlow, len));
    rdy_i = rlow ? 1'b1 : 1'b0;
    wr(2'd0, 8'(data));
    chk("R2", "rdy_o after data write", int'(rdy_o), 1);
    chk("R4", "rdy_o_n while ready", int'(rdy_o_n), 0);
    falls = 0; rises = 0;
    repeat (4 * (d + 1)) @(negedge clk);
    chk("R12", "no clock with ready inactive", falls, 0);
    rdy_i = rlow ? 1'b0 : 1'b1;
    begin
      int t0;
      t0 = cyc;
      for (int k = 0; k < 400 && falls == 0; k++) @(negedge clk);
      chk_rng("R5", "cycles to first clock fall", first_fall - t0, lo, lo + 4);
    end
    chk("R3", "rdy_o after first fall", int'(rdy_o), 0);
    chk("R4", "rdy_o_n after first fall", int'(rdy_o_n), 1);
    chk("R8", "busy during transfer", int'(busy_o), 1);
    rdy_i = rlow ? 1'b1 : 1'b0;
    wait_busy_low();
    repeat (4 * (d + 1)) @(negedge clk);
    chk("R7", "falling edges", falls, n);
    chk("R8", "rising edges", rises, n);
    chk("R8", "sclk idle level", int'(sclk_o), 1);
    chk("R6", "busy cleared after full length", int'(busy_o), 0);
    rd(2'd3, v);
    chk("R11", "done after transfer", int'(v[0]), 1);
    rd(2'd0, v);
    chk("R10", "looped word", int'(v), rotr(data, n));
    rd(2'd3, v);
    chk("R11", "done after data read", int'(v[0]), 0);
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
    sclk_i = 1'b1; rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1", "reset rdy_o", int'(rdy_o), 0);
    chk("R4", "reset rdy_o_n", int'(rdy_o_n), 1);
    chk("R8", "reset busy", int'(busy_o), 0);
    chk("R8", "reset sclk", int'(sclk_o), 1);

    // disabled: writes ignored
    wr(2'd0, 8'h5A);
    chk("R1", "rdy_o while disabled", int'(rdy_o), 0);
    rd(2'd0, v);
    chk("R1", "data unchanged while disabled", int'(v), 0);

    // clearing enable drops ready
    wr(2'd1, ctl(1, 0, 0, 0, 0));
    wr(2'd0, 8'h11);
    chk("R2", "rdy_o set", int'(rdy_o), 1);
    wr(2'd1, ctl(0, 0, 0, 0, 0));
    @(negedge clk);
    chk("R1", "rdy_o after disable", int'(rdy_o), 0);

    // short ready pulse: no clock
    begin
      int d;
      d = 2;
      wr(2'd2, 8'(d));
      wr(2'd1, ctl(1, 0, 0, 0, 0));
      wr(2'd0, 8'h3C);
      falls = 0;
      rdy_i = 1'b1;
      repeat (2 * (d + 1) + 1) @(negedge clk);
      rdy_i = 1'b0;
      repeat (10 * (d + 1)) @(negedge clk);
      chk("R5", "falls after short ready", falls, 0);
      chk("R5", "still ready after short pulse", int'(rdy_o), 1);
      rdy_i = 1'b1;
      for (int k = 0; k < 400 && falls == 0; k++) @(negedge clk);
      rdy_i = 1'b0;
      wait_busy_low();
      rd(2'd0, v);
      chk("R10", "word after retry", int'(v), 8'h3C);
    end

    // sweep: divider x length x pattern x polarity
    for (int d = 1; d <= 3; d++) begin
      for (int l = 0; l <= 8; l++) begin
        run_int(d, (l < 8) ? 1 : 0, (l < 8) ? l : 0, 8'hA5 ^ (l * 17), l & 1);
        run_int(d, (l < 8) ? 1 : 0, (l < 8) ? l : 0, 8'h1E + d * 37 + l, (l + d) & 1);
      end
    end

    // external clock
    wr(2'd1, ctl(1, 1, 1, 0, 4));
    rdy_i = 1'b0;
    wr(2'd0, 8'hC3);
    repeat (10) @(negedge clk);
    chk("R9", "busy before ready in", int'(busy_o), 0);
    rdy_i = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9", "busy after ready in", int'(busy_o), 1);
    for (int b = 0; b < 5; b++) begin
      sclk_i = 1'b0;
      repeat (6) @(negedge clk);
      if (b == 0) chk("R3", "rdy_o after external fall", int'(rdy_o), 0);
      sclk_i = 1'b1;
      repeat (6) @(negedge clk);
    end
    rdy_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8", "busy after external transfer", int'(busy_o), 0);
    chk("R8", "sclk_o held in external mode", int'(sclk_o), 1);
    rd(2'd0, v);
    chk("R10", "external looped word", int'(v), rotr(8'hC3, 5));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule